// File: doc/BRIEF.md
# Frozen-Copy Timekeeping Register Window

This block exposes the time and calendar of a running counting core as eight byte-wide registers at the top of a memory-mapped window. The registers hold a user-visible copy of the time. While neither freeze bit is set, the copy follows the core's live counters one clock behind. A host can freeze the copy for reading, or freeze it for writing. When it freezes the copy for writing, the host edits the fields and then releases the write freeze. That release loads the edited values into the core in a single transfer. Accesses anywhere else in the window pass straight to a plain RAM port.

The control register also carries the century. Only the write that releases the write freeze changes the century. The seconds register carries an oscillator-stop bit that drives the core's stop input. The day register carries a frequency-test bit and a battery-good flag that comes from a pin. With frequency test on and the oscillator running, the seconds LSB reads back the core's 512 Hz square wave.

Top module: `rtc_shadow_regs`

## Requirements
- R1: The register window is the eight addresses with all upper address bits set. Offset 7 is year (8 bits), 6 is month (bits 4:0), 5 is date (bits 5:0), 4 is day (bits 2:0), 3 is hours (bits 5:0), 2 is minutes (bits 6:0), 1 is seconds (bits 6:0) and 0 is control. Any other address drives ram_en, with ram_we set on a write, and forwards the address and write data to the RAM port unchanged.
- R2: A read (bus_cs and bus_rd with bus_wr low) returns its data on bus_rdata in the next cycle. For a RAM address that data is ram_rdata, which the RAM returns one cycle after the request.
- R3: While the read-freeze and write-freeze bits are both 0, every field of the copy takes the value of live_time one cycle later, and writes to time fields are dropped.
- R4: While either freeze bit is 1, the copy holds its value. A write to a time field stores its masked byte, and a later read returns that byte.
- R5: A control write with bit 7 = 0 while the write-freeze bit is 1 pulses core_load for exactly one cycle in the next cycle. In that cycle core_set carries the copy, with the century equal to write data bits 5:0 (if bit 6 is also 0). The core is then expected to count on from those values.
- R6: A control write made while the write-freeze bit is 0 never pulses core_load, and it leaves the century unchanged. Once both freeze bits are 0, the copy refreshes from live_time.
- R7: Control reads back as {write-freeze, read-freeze, century[5:0]}. The century in the copy is left unchanged by any control write that sets bit 7 or bit 6.
- R8: Seconds bit 7 is the oscillator-stop bit. A write stores it at any time, it drives osc_stop, and it reads back in seconds bit 7.
- R9: Day bit 7 always reads as the batt_ok pin and cannot be written. Day bit 6 is the stored frequency-test bit.
- R10: When the frequency-test bit is 1 and the oscillator-stop bit is 0, the seconds LSB reads as sq_512 sampled at the read. Otherwise it reads as the copy's LSB.
- R11: Unused register bits read as 0, and written values lose them.
- R12: Reset clears both freeze bits, the oscillator-stop bit, the frequency-test bit, the copy, core_load and bus_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Host select |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, one cycle after the read |
| ram_en | output | 1 | RAM access outside the register window |
| ram_we | output | 1 | RAM write |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the request |
| live_time | input | 48 | Live counters from the core, packed {year, month, date, day, hour, min, sec, century} |
| sq_512 | input | 1 | 512 Hz square wave from the core |
| batt_ok | input | 1 | Battery good when 1 |
| core_load | output | 1 | One-cycle load strobe to the core |
| core_set | output | 48 | Values to load, same packing as live_time |
| osc_stop | output | 1 | Oscillator stop to the core |

## Verification
A copy stuck in its frozen state shows up as stale readback. It appears at the first read made at least two cycles after the freeze bits clear, because the live core keeps moving. A wrong freeze bit, or a wrong century update, shows up at the very next control read. A missed or doubled transfer shows up on core_load and core_set one cycle after the control write, well before any later read would reveal it. A seconds readback that keeps changing while the oscillator is stopped points to a bad oscillator-stop bit.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int TIME_W = 48;
  localparam int NREGS  = 8;

  typedef struct packed {
    logic [7:0] year;
    logic [4:0] month;
    logic [5:0] date;
    logic [2:0] day;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
    logic [5:0] cent;
  } rtc_time_t;

  localparam logic [2:0] OFF_CTRL  = 3'd0;
  localparam logic [2:0] OFF_SEC   = 3'd1;
  localparam logic [2:0] OFF_MIN   = 3'd2;
  localparam logic [2:0] OFF_HOUR  = 3'd3;
  localparam logic [2:0] OFF_DAY   = 3'd4;
  localparam logic [2:0] OFF_DATE  = 3'd5;
  localparam logic [2:0] OFF_MONTH = 3'd6;
  localparam logic [2:0] OFF_YEAR  = 3'd7;
endpackage

// File: rtl/rtc_user_copy.sv
module rtc_user_copy
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       freeze,
  input  rtc_time_t  live,
  input  logic [7:1] fld_we,
  input  logic       cent_we,
  input  logic [7:0] wdata,
  output rtc_time_t  user
);
  always_ff @(posedge clk) begin
    if (rst) begin
      user <= '0;
    end else if (!freeze) begin
      user <= live;
    end else begin
      if (fld_we[OFF_YEAR])  user.year  <= wdata;
      if (fld_we[OFF_MONTH]) user.month <= wdata[4:0];
      if (fld_we[OFF_DATE])  user.date  <= wdata[5:0];
      if (fld_we[OFF_DAY])   user.day   <= wdata[2:0];
      if (fld_we[OFF_HOUR])  user.hour  <= wdata[5:0];
      if (fld_we[OFF_MIN])   user.min   <= wdata[6:0];
      if (fld_we[OFF_SEC])   user.sec   <= wdata[6:0];
      if (cent_we)           user.cent  <= wdata[5:0];
    end
  end

  // R3: unfrozen copy trails the live counters by one cycle
  a_r3_follow_live: assert property (@(posedge clk) disable iff (rst)
    !freeze |=> (user == $past(live)));

  // R4: frozen copy with no field write keeps its value
  a_r4_frozen_hold: assert property (@(posedge clk) disable iff (rst)
    (freeze && (fld_we == '0) && !cent_we) |=> $stable(user));
endmodule

// File: rtl/rtc_ctrl_unit.sv
module rtc_ctrl_unit
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_we,
  input  logic       sec_we,
  input  logic       day_we,
  input  logic [7:0] wdata,
  input  rtc_time_t  user,
  output logic       w_q,
  output logic       r_q,
  output logic       osc_q,
  output logic       ft_q,
  output logic       cent_we,
  output logic       core_load,
  output rtc_time_t  core_set
);
  logic clr_w;

  always_comb begin
    clr_w   = ctrl_we && w_q && !wdata[7];
    cent_we = clr_w && !wdata[6];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q       <= 1'b0;
      r_q       <= 1'b0;
      osc_q     <= 1'b0;
      ft_q      <= 1'b0;
      core_load <= 1'b0;
      core_set  <= '0;
    end else begin
      core_load <= clr_w;
      if (clr_w) begin
        core_set      <= user;
        core_set.cent <= cent_we ? wdata[5:0] : user.cent;
      end
      if (ctrl_we) begin
        w_q <= wdata[7];
        r_q <= wdata[6];
      end
      if (sec_we) osc_q <= wdata[7];
      if (day_we) ft_q  <= wdata[6];
    end
  end

  // R5: the load strobe lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    core_load |=> !core_load);

  // R5: a load only follows the write-freeze bit falling
  a_r5_load_on_w_fall: assert property (@(posedge clk) disable iff (rst)
    core_load |-> (!w_q && $past(w_q)));

  // R6: a control write without write-freeze never loads
  a_r6_no_load: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !w_q) |=> !core_load);
endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_hit,
  input  logic       rd_ram,
  input  logic [2:0] off,
  input  rtc_time_t  user,
  input  logic       w_q,
  input  logic       r_q,
  input  logic       osc_q,
  input  logic       ft_q,
  input  logic       batt_ok,
  input  logic       sq_512,
  input  logic [7:0] ram_rdata,
  output logic [7:0] rdata
);
  logic [7:0] reg_q;
  logic       sel_ram_q;
  logic [7:0] field;
  logic       sec_lsb;

  always_comb begin
    sec_lsb = (ft_q && !osc_q) ? sq_512 : user.sec[0];
    unique case (off)
      OFF_YEAR:  field = user.year;
      OFF_MONTH: field = {3'b0, user.month};
      OFF_DATE:  field = {2'b0, user.date};
      OFF_DAY:   field = {batt_ok, ft_q, 3'b0, user.day};
      OFF_HOUR:  field = {2'b0, user.hour};
      OFF_MIN:   field = {1'b0, user.min};
      OFF_SEC:   field = {osc_q, user.sec[6:1], sec_lsb};
      default:   field = {w_q, r_q, user.cent};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      sel_ram_q <= 1'b0;
    end else begin
      if (rd_hit) begin
        reg_q     <= field;
        sel_ram_q <= 1'b0;
      end else if (rd_ram) begin
        sel_ram_q <= 1'b1;
      end
    end
  end

  assign rdata = sel_ram_q ? ram_rdata : reg_q;
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_cs,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic                ram_en,
  output logic                ram_we,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic [7:0]          ram_wdata,
  input  logic [7:0]          ram_rdata,
  input  logic [TIME_W-1:0]   live_time,
  input  logic                sq_512,
  input  logic                batt_ok,
  output logic                core_load,
  output logic [TIME_W-1:0]   core_set,
  output logic                osc_stop
);
  localparam int OFF_W = $clog2(NREGS);

  logic             hit;
  logic [OFF_W-1:0] off;
  logic             we_hit;
  logic             rd_hit;
  logic             rd_ram;
  logic [NREGS-1:0] fld_we;
  logic             w_q, r_q, osc_q, ft_q, cent_we;
  rtc_time_t        user;
  rtc_time_t        live;
  rtc_time_t        set_s;

  always_comb begin
    hit    = bus_cs && (&bus_addr[ADDR_W-1:OFF_W]);
    off    = bus_addr[OFF_W-1:0];
    we_hit = hit && bus_wr;
    rd_hit = hit && bus_rd && !bus_wr;
    ram_en = bus_cs && !hit;
    ram_we = ram_en && bus_wr;
    rd_ram = ram_en && bus_rd && !bus_wr;
    live   = rtc_time_t'(live_time);
  end

  assign ram_addr  = bus_addr;
  assign ram_wdata = bus_wdata;

  for (genvar i = 0; i < NREGS; i++) begin : g_we
    assign fld_we[i] = we_hit && (off == OFF_W'(i));
  end

  rtc_ctrl_unit u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ctrl_we   (fld_we[OFF_CTRL]),
    .sec_we    (fld_we[OFF_SEC]),
    .day_we    (fld_we[OFF_DAY]),
    .wdata     (bus_wdata),
    .user      (user),
    .w_q       (w_q),
    .r_q       (r_q),
    .osc_q     (osc_q),
    .ft_q      (ft_q),
    .cent_we   (cent_we),
    .core_load (core_load),
    .core_set  (set_s)
  );

  rtc_user_copy u_copy (
    .clk     (clk),
    .rst     (rst),
    .freeze  (w_q || r_q),
    .live    (live),
    .fld_we  (fld_we[NREGS-1:1]),
    .cent_we (cent_we),
    .wdata   (bus_wdata),
    .user    (user)
  );

  rtc_read_mux u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_hit    (rd_hit),
    .rd_ram    (rd_ram),
    .off       (off),
    .user      (user),
    .w_q       (w_q),
    .r_q       (r_q),
    .osc_q     (osc_q),
    .ft_q      (ft_q),
    .batt_ok   (batt_ok),
    .sq_512    (sq_512),
    .ram_rdata (ram_rdata),
    .rdata     (bus_rdata)
  );

  assign core_set = set_s;
  assign osc_stop = osc_q;
endmodule

// File: tb/sim_rtc_shadow_regs.sv
module sim_rtc_shadow_regs;
  import rtc_pkg::*;
  localparam int AW = 17;
  localparam logic [AW-1:0] TOP = 17'h1FFF8;

  logic clk = 0, rst = 1;
  logic bus_cs = 0, bus_rd = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata = '0;
  rtc_time_t live;
  logic [TIME_W-1:0] core_set;
  logic core_load, osc_stop;
  logic sq = 0, batt_ok = 1;

  int tests = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  rtc_shadow_regs #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .live_time(live), .sq_512(sq), .batt_ok(batt_ok),
    .core_load(core_load), .core_set(core_set), .osc_stop(osc_stop));

  // behavioural counting core and RAM
  logic [7:0] mem [16];
  int tick;
  always @(posedge clk) begin
    if (rst) begin
      live <= '{year:8'h24, month:5'h12, date:6'h28, day:3'h5, hour:6'h23,
                min:7'h59, sec:7'h00, cent:6'h20};
      tick <= 0;
    end else if (core_load) begin
      live <= rtc_time_t'(core_set);
    end else begin
      tick <= (tick == 3) ? 0 : tick + 1;
      if (tick == 3 && !osc_stop) live.sec <= (live.sec == 7'h59) ? 7'h00 : live.sec + 7'h01;
    end
    if (ram_en && ram_we) mem[ram_addr[3:0]] <= ram_wdata;
    if (ram_en && !ram_we) ram_rdata <= mem[ram_addr[3:0]];
  end

  int sqc = 0;
  always @(negedge clk) begin
    #1;
    sqc = sqc + 1;
    if (sqc % 3 == 0) sq = ~sq;
  end

  // reference model
  rtc_time_t m_user;
  logic m_w, m_r, m_osc, m_ft, m_load, m_rdv;
  logic [TIME_W-1:0] m_set;
  logic [7:0] m_rdata;
  logic m_hit;
  logic [2:0] m_off;

  function automatic logic [7:0] rb(input logic [2:0] o);
    case (o)
      3'd7: rb = m_user.year;
      3'd6: rb = {3'b0, m_user.month};
      3'd5: rb = {2'b0, m_user.date};
      3'd4: rb = {batt_ok, m_ft, 3'b0, m_user.day};
      3'd3: rb = {2'b0, m_user.hour};
      3'd2: rb = {1'b0, m_user.min};
      3'd1: rb = {m_osc, m_user.sec[6:1], (m_ft && !m_osc) ? sq : m_user.sec[0]};
      default: rb = {m_w, m_r, m_user.cent};
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_user <= '0; m_w <= 0; m_r <= 0; m_osc <= 0; m_ft <= 0;
      m_load <= 0; m_set <= '0; m_rdv <= 0; m_rdata <= '0;
    end else begin
      m_hit = bus_cs && (bus_addr[AW-1:3] == TOP[AW-1:3]);
      m_off = bus_addr[2:0];
      m_load <= 0;
      if (!(m_w || m_r)) m_user <= live;
      else if (m_hit && bus_wr) begin
        case (m_off)
          3'd7: m_user.year  <= bus_wdata;
          3'd6: m_user.month <= bus_wdata[4:0];
          3'd5: m_user.date  <= bus_wdata[5:0];
          3'd4: m_user.day   <= bus_wdata[2:0];
          3'd3: m_user.hour  <= bus_wdata[5:0];
          3'd2: m_user.min   <= bus_wdata[6:0];
          3'd1: m_user.sec   <= bus_wdata[6:0];
          default: if (m_w && bus_wdata[7:6] == 2'b00) m_user.cent <= bus_wdata[5:0];
        endcase
      end
      if (m_hit && bus_wr) begin
        if (m_off == 3'd0) begin
          if (m_w && !bus_wdata[7]) begin
            m_load <= 1;
            m_set  <= {m_user.year, m_user.month, m_user.date, m_user.day, m_user.hour,
                       m_user.min, m_user.sec,
                       bus_wdata[6] ? m_user.cent : bus_wdata[5:0]};
          end
          m_w <= bus_wdata[7];
          m_r <= bus_wdata[6];
        end
        if (m_off == 3'd1) m_osc <= bus_wdata[7];
        if (m_off == 3'd4) m_ft  <= bus_wdata[6];
      end
      m_rdv <= bus_cs && bus_rd && !bus_wr;
      if (bus_cs && bus_rd && !bus_wr) m_rdata <= m_hit ? rb(m_off) : mem[bus_addr[3:0]];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 core_load", core_load, m_load);
      chk("R8 osc_stop", osc_stop, m_osc);
      chk("R1 ram_en", ram_en, bus_cs && (bus_addr[AW-1:3] != TOP[AW-1:3]));
      if (m_load) chk("R5 core_set", core_set, m_set);
      if (m_rdv)  chk("R2 bus_rdata", bus_rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      fails++; tests++;
      $display("FAIL watchdog R12 actual=%0d expected=<50000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic sq_at);
    @(negedge clk);
    bus_cs = 1; bus_rd = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; sq_at = sq;
    bus_cs = 0; bus_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [7:0] v, s1;
  logic sqv;

  initial begin
    idle(3);
    chk("R12 rdata in reset", bus_rdata, 8'h00);
    chk("R12 core_load in reset", core_load, 1'b0);
    chk("R12 osc_stop in reset", osc_stop, 1'b0);
    @(negedge clk); rst = 0;
    idle(3);

    // R1 map and R3 live following
    rd(TOP + 7, v, sqv); chk("R1 R3 year", v, 8'h24);
    rd(TOP + 6, v, sqv); chk("R1 month", v, 8'h12);
    rd(TOP + 5, v, sqv); chk("R1 date", v, 8'h28);
    rd(TOP + 3, v, sqv); chk("R1 hour", v, 8'h23);
    rd(TOP + 4, v, sqv); chk("R9 day batt", v, 8'h85);
    rd(TOP + 0, v, sqv); chk("R12 ctrl after reset", v, 8'h20);
    wr(TOP + 7, 8'h77); idle(2);
    rd(TOP + 7, v, sqv); chk("R3 write dropped", v, 8'h24);

    // read freeze
    wr(TOP + 0, 8'h40);
    rd(TOP + 0, v, sqv); chk("R7 set R keeps century", v, 8'h60);
    rd(TOP + 1, s1, sqv); idle(12);
    rd(TOP + 1, v, sqv); chk("R4 frozen seconds", v, s1);
    wr(TOP + 7, 8'h99);
    rd(TOP + 7, v, sqv); chk("R4 frozen write", v, 8'h99);
    wr(TOP + 6, 8'hFF);
    rd(TOP + 6, v, sqv); chk("R11 month mask", v, 8'h1F);
    wr(TOP + 0, 8'h05);
    chk("R6 no load on R clear", core_load, 1'b0);
    idle(3);
    rd(TOP + 7, v, sqv); chk("R6 refresh resumes", v, 8'h24);
    rd(TOP + 0, v, sqv); chk("R6 century kept", v, 8'h20);

    // write freeze and transfer
    wr(TOP + 0, 8'h95);
    rd(TOP + 0, v, sqv); chk("R7 set W keeps century", v, 8'hA0);
    wr(TOP + 7, 8'h31); wr(TOP + 6, 8'h07); wr(TOP + 5, 8'hD4);
    wr(TOP + 4, 8'h03); wr(TOP + 3, 8'h08); wr(TOP + 2, 8'h30);
    wr(TOP + 1, 8'h45);
    rd(TOP + 5, v, sqv); chk("R11 date mask", v, 8'h14);
    wr(TOP + 0, 8'h21);
    chk("R5 load pulse", core_load, 1'b1);
    chk("R5 load values", core_set,
        {8'h31, 5'h07, 6'h14, 3'h3, 6'h08, 7'h30, 7'h45, 6'h21});
    idle(1);
    chk("R5 pulse ends", core_load, 1'b0);
    idle(2);
    rd(TOP + 7, v, sqv); chk("R5 core continues", v, 8'h31);
    rd(TOP + 0, v, sqv); chk("R5 century loaded", v, 8'h21);

    // oscillator stop
    wr(TOP + 1, 8'h80);
    chk("R8 osc_stop set", osc_stop, 1'b1);
    idle(2);
    rd(TOP + 1, s1, sqv); idle(20);
    rd(TOP + 1, v, sqv); chk("R8 stopped seconds", v, s1);
    chk("R8 readback bit", v[7], 1'b1);
    wr(TOP + 4, 8'h40);
    rd(TOP + 1, v, sqv); chk("R10 stopped ignores sq", v, s1);
    wr(TOP + 1, 8'h00);
    chk("R8 osc_stop clear", osc_stop, 1'b0);

    // frequency test
    for (int k = 0; k < 4; k++) begin
      rd(TOP + 1, v, sqv); chk("R10 lsb follows sq", v[0], sqv);
      idle(k + 1);
    end
    batt_ok = 0;
    rd(TOP + 4, v, sqv); chk("R9 batt low, ft on", v, 8'h43);
    wr(TOP + 4, 8'h80);
    rd(TOP + 4, v, sqv); chk("R9 batt not writable", v, 8'h03);
    batt_ok = 1;

    // RAM pass-through
    wr(17'h00005, 8'hA5);
    wr(17'h1FFF7, 8'h3C);
    rd(17'h00005, v, sqv); chk("R1 ram read", v, 8'hA5);
    rd(17'h1FFF7, v, sqv); chk("R1 R2 below window", v, 8'h3C);
    idle(4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule